// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to the control path of a simple 32-bit core and owns the processor status word. It takes exception requests from the core and selects the most urgent one that is currently allowed. It then performs the entry in one step. The old status is kept in the saved-status slot of the mode being entered. The status word takes the new mode, the 32-bit instruction state and the needed interrupt masks. A link value is produced for the register file, and the fetch unit receives a one-cycle redirect to the vector address.

The same block handles the exit from an exception. When the core asks to return, the status word is reloaded from the saved slot of the current mode. The fetch unit is redirected to the link value, minus the correction recorded when that mode was entered. An ordinary status write port lets the core load the status word directly. Reset is asynchronous. After reset is released, the block first issues a redirect to the reset vector.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `status_o` reads 0xD3: mode field bits[4:0] = 10011 (supervisor), bit 5 (state) = 0, bit 6 (fast mask) = 1 and bit 7 (normal mask) = 1. `redirect_o` is low. In the first cycle after release, `redirect_o` pulses with `redirect_pc_o` = selected vector base + 0x00, and `link_we_o` stays low.
- R2: Requests that arrive together are resolved in the same cycle. The order is data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt, undefined instruction; a software interrupt beats an undefined-instruction request raised in the same cycle. A request that loses and stays asserted is taken later.
- R3: A normal interrupt request is not eligible while status bit 7 is 1, and a fast interrupt request is not eligible while bit 6 is 1. A request that is not eligible causes no redirect and leaves the status word unchanged.
- R4: On entry, the previous status word is stored in the saved slot of the target mode. The mode field is then set to the target mode code: fast interrupt 10001, normal interrupt 10010, supervisor 10011, abort 10111, undefined 11011 (user is 10000, system 11111). Bit 5 is cleared and bit 7 is set. Bit 6 is also set for fast interrupt entry, and any other status bit keeps its value.
- R5: On entry, `link_we_o` pulses together with `redirect_o`, with `link_mode_o` = target mode code and `link_data_o` = `cur_pc` - 4. A software interrupt taken in supervisor mode overwrites that mode's saved slot and link.
- R6: The vector is the base (0x00000000 when `hi_vec_sel` = 0, 0xFFFF0000 when 1) plus an offset: undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R7: Outputs change at the clock edge that ends the cycle of selection. `redirect_o` is high for exactly one cycle. No entry or return is started in a cycle where `redirect_o` is high.
- R8: When `ret_req` is high and the mode has a saved slot and bit 5 is 0, the status word is restored from that slot. `redirect_o` pulses with `ret_link` minus a correction set at entry: 0 for software interrupt and undefined, 4 for fast interrupt, normal interrupt and prefetch abort, 8 for data abort.
- R9: A return request in user or system mode, or with bit 5 set, is ignored: there is no redirect and the status word is unchanged.
- R10: `stat_wr_en` loads `stat_wr_data` into the status word at the next edge when no entry or return happens in that cycle. An entry in the same cycle wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_dabt | input | 1 | Data abort request (level) |
| req_fiq | input | 1 | Fast interrupt request (level) |
| req_irq | input | 1 | Normal interrupt request (level) |
| req_pabt | input | 1 | Prefetch abort request (level) |
| req_swi | input | 1 | Software interrupt request (level) |
| req_und | input | 1 | Undefined instruction request (level) |
| hi_vec_sel | input | 1 | Vector table base select |
| cur_pc | input | 32 | Current PC value from the core |
| ret_req | input | 1 | Exception return request |
| ret_link | input | 32 | Link value of the current mode for return |
| stat_wr_en | input | 1 | Direct status word write enable |
| stat_wr_data | input | 32 | Direct status word write data |
| status_o | output | 32 | Current status word |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target address |
| link_we_o | output | 1 | Link register write strobe |
| link_mode_o | output | 5 | Mode whose link register is written |
| link_data_o | output | 32 | Link value to write |

## Verification
The hardest case is a nested entry. A lower-priority request loses, stays pending through the one-cycle lockout after the winner, and is then taken from inside the winner's mode. To check this, the saved slot of the second mode must hold the first exception's status, and two unwinding returns must each apply a different correction. The stimulus raises data abort together with fast interrupt, and normal interrupt together with prefetch abort. The winner is withdrawn only when its redirect appears, while the loser stays high and `cur_pc` is moved. The two returns then follow in reverse order, and every redirect is matched against a queue of expected items.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

   localparam int unsigned NUM_SRC = 6;
   localparam int unsigned BANK_W  = 3;
   localparam int unsigned BIT_T   = 5;
   localparam int unsigned BIT_F   = 6;
   localparam int unsigned BIT_I   = 7;

   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } mode_e;

   // index order is the priority order, lowest index wins
   typedef enum logic [2:0] {
      SRC_DABT = 3'd0,
      SRC_FIQ  = 3'd1,
      SRC_IRQ  = 3'd2,
      SRC_PABT = 3'd3,
      SRC_SWI  = 3'd4,
      SRC_UND  = 3'd5
   } src_e;

   typedef struct packed {
      logic [4:0] mode;
      logic       set_f;
      logic [4:0] vec_off;
      logic [1:0] adj;     // return correction in words: 0, 1 or 2
   } entry_attr_t;

   function automatic entry_attr_t attr_of(src_e s);
      entry_attr_t a;
      case (s)
         SRC_DABT: a = '{mode: MODE_ABT, set_f: 1'b0, vec_off: 5'h10, adj: 2'd2};
         SRC_FIQ:  a = '{mode: MODE_FIQ, set_f: 1'b1, vec_off: 5'h1C, adj: 2'd1};
         SRC_IRQ:  a = '{mode: MODE_IRQ, set_f: 1'b0, vec_off: 5'h18, adj: 2'd1};
         SRC_PABT: a = '{mode: MODE_ABT, set_f: 1'b0, vec_off: 5'h0C, adj: 2'd1};
         SRC_SWI:  a = '{mode: MODE_SVC, set_f: 1'b0, vec_off: 5'h08, adj: 2'd0};
         default:  a = '{mode: MODE_UND, set_f: 1'b0, vec_off: 5'h04, adj: 2'd0};
      endcase
      return a;
   endfunction

   // saved-status slot of a mode; all ones means the mode owns none
   function automatic logic [BANK_W-1:0] bank_of(logic [4:0] m);
      logic [BANK_W-1:0] b;
      case (m)
         MODE_FIQ: b = 3'd0;
         MODE_IRQ: b = 3'd1;
         MODE_SVC: b = 3'd2;
         MODE_ABT: b = 3'd3;
         MODE_UND: b = 3'd4;
         default:  b = '1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/exc_prio_sel.sv
`timescale 1ns/1ps
module exc_prio_sel #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   if (N < 2) begin : g_bad_n
      $error("exc_prio_sel: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_gnt
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_lower
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   assign any = |req;

endmodule

// File: rtl/exc_vec_gen.sv
`timescale 1ns/1ps
module exc_vec_gen #(
   parameter int unsigned      XLEN    = 32,
   parameter logic [XLEN-1:0]  LO_BASE = '0,
   parameter logic [XLEN-1:0]  HI_BASE = XLEN'(32'hFFFF_0000),
   parameter int unsigned      OFF_W   = 5
) (
   input  logic             hi_sel,
   input  logic [OFF_W-1:0] off,
   output logic [XLEN-1:0]  addr
);

   if (LO_BASE[OFF_W-1:0] != '0 || HI_BASE[OFF_W-1:0] != '0) begin : g_bad_base
      $error("exc_vec_gen: vector bases must be aligned to the table size");
   end

   logic [XLEN-1:0] base;
   assign base = hi_sel ? HI_BASE : LO_BASE;
   assign addr = base + XLEN'(off);

endmodule

// File: rtl/exc_spsr_bank.sv
`timescale 1ns/1ps
module exc_spsr_bank #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned NBANK  = 5,
   parameter int unsigned IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  wr_stat,
   input  logic [1:0]       wr_adj,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [XLEN-1:0]  rd_stat,
   output logic [1:0]       rd_adj
);

   if (NBANK >= (1 << IDX_W)) begin : g_bad_idx
      $error("exc_spsr_bank: index width too small for bank count");
   end

   logic [XLEN-1:0] stat_q [NBANK];
   logic [1:0]      adj_q  [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q[b] <= '0;
            adj_q[b]  <= '0;
         end else if (wr_en && wr_idx == IDX_W'(b)) begin
            stat_q[b] <= wr_stat;
            adj_q[b]  <= wr_adj;
         end
      end
   end

   always_comb begin
      rd_stat = '0;
      rd_adj  = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (rd_idx == IDX_W'(b)) begin
            rd_stat = stat_q[b];
            rd_adj  = adj_q[b];
         end
      end
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl #(
   parameter int unsigned     XLEN    = 32,
   parameter logic [XLEN-1:0] LO_BASE = '0,
   parameter logic [XLEN-1:0] HI_BASE = XLEN'(32'hFFFF_0000)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_dabt,
   input  logic            req_fiq,
   input  logic            req_irq,
   input  logic            req_pabt,
   input  logic            req_swi,
   input  logic            req_und,
   input  logic            hi_vec_sel,
   input  logic [XLEN-1:0] cur_pc,
   input  logic            ret_req,
   input  logic [XLEN-1:0] ret_link,
   input  logic            stat_wr_en,
   input  logic [XLEN-1:0] stat_wr_data,
   output logic [XLEN-1:0] status_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_pc_o,
   output logic            link_we_o,
   output logic [4:0]      link_mode_o,
   output logic [XLEN-1:0] link_data_o
);
   import exc_pkg::*;

   localparam int unsigned NBANK   = 5;
   localparam int unsigned OFF_W   = 5;
   localparam logic [XLEN-1:0] RST_STATUS = XLEN'(8'hD3);

   if (XLEN < 8) begin : g_bad_xlen
      $error("exc_entry_ctrl: XLEN must hold the 8 status control bits");
   end

   logic [XLEN-1:0] status_q;
   logic            boot_q;
   logic            redirect_q;
   logic [XLEN-1:0] pc_q;
   logic            link_we_q;
   logic [4:0]      link_mode_q;
   logic [XLEN-1:0] link_data_q;

   // ---------------- selection ----------------
   logic                busy;
   logic [NUM_SRC-1:0]  elig;
   logic [NUM_SRC-1:0]  grant;
   logic                take;
   src_e                src;
   entry_attr_t         attr;

   assign busy = boot_q | redirect_q;

   always_comb begin
      elig              = '0;
      elig[SRC_DABT]    = req_dabt;
      elig[SRC_FIQ]     = req_fiq & ~status_q[BIT_F];
      elig[SRC_IRQ]     = req_irq & ~status_q[BIT_I];
      elig[SRC_PABT]    = req_pabt;
      elig[SRC_SWI]     = req_swi;
      elig[SRC_UND]     = req_und;
      if (busy) elig    = '0;
   end

   exc_prio_sel #(.N(NUM_SRC)) u_prio (
      .req   (elig),
      .grant (grant),
      .any   (take)
   );

   always_comb begin
      src = SRC_DABT;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) src = src_e'(3'(i));
      end
   end

   assign attr = attr_of(src);

   // ---------------- vector ----------------
   logic [OFF_W-1:0] vec_off;
   logic [XLEN-1:0]  vec_addr;

   assign vec_off = boot_q ? '0 : attr.vec_off;

   exc_vec_gen #(
      .XLEN(XLEN), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .OFF_W(OFF_W)
   ) u_vec (
      .hi_sel (hi_vec_sel),
      .off    (vec_off),
      .addr   (vec_addr)
   );

   // ---------------- saved status ----------------
   logic [BANK_W-1:0] cur_bank;
   logic [BANK_W-1:0] tgt_bank;
   logic [XLEN-1:0]   saved_stat;
   logic [1:0]        saved_adj;
   logic              ret_ok;

   assign cur_bank = bank_of(status_q[4:0]);
   assign tgt_bank = bank_of(attr.mode);
   assign ret_ok   = ret_req & ~busy & ~take & ~status_q[BIT_T]
                   & (cur_bank != '1);

   exc_spsr_bank #(.XLEN(XLEN), .NBANK(NBANK), .IDX_W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take),
      .wr_idx  (tgt_bank),
      .wr_stat (status_q),
      .wr_adj  (attr.adj),
      .rd_idx  (cur_bank),
      .rd_stat (saved_stat),
      .rd_adj  (saved_adj)
   );

   // ---------------- next status ----------------
   logic [XLEN-1:0] entry_stat;
   logic [XLEN-1:0] ret_pc;

   always_comb begin
      entry_stat         = status_q;
      entry_stat[4:0]    = attr.mode;
      entry_stat[BIT_T]  = 1'b0;
      entry_stat[BIT_I]  = 1'b1;
      if (attr.set_f) entry_stat[BIT_F] = 1'b1;
   end

   assign ret_pc = ret_link - XLEN'({saved_adj, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q    <= RST_STATUS;
         boot_q      <= 1'b1;
         redirect_q  <= 1'b0;
         pc_q        <= '0;
         link_we_q   <= 1'b0;
         link_mode_q <= MODE_SVC;
         link_data_q <= '0;
      end else begin
         boot_q     <= 1'b0;
         redirect_q <= 1'b0;
         link_we_q  <= 1'b0;
         if (boot_q) begin
            redirect_q <= 1'b1;
            pc_q       <= vec_addr;
         end else if (take) begin
            status_q    <= entry_stat;
            redirect_q  <= 1'b1;
            pc_q        <= vec_addr;
            link_we_q   <= 1'b1;
            link_mode_q <= attr.mode;
            link_data_q <= cur_pc - XLEN'(4);
         end else if (ret_ok) begin
            status_q   <= saved_stat;
            redirect_q <= 1'b1;
            pc_q       <= ret_pc;
         end else if (stat_wr_en) begin
            status_q <= stat_wr_data;
         end
      end
   end

   assign status_o      = status_q;
   assign redirect_o    = redirect_q;
   assign redirect_pc_o = pc_q;
   assign link_we_o     = link_we_q;
   assign link_mode_o   = link_mode_q;
   assign link_data_o   = link_data_q;

endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       redirect_o,
   input logic       link_we_o,
   input logic [4:0] link_mode_o,
   input logic [7:0] stat_lo
);
   import exc_pkg::*;

   AST_REDIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !redirect_o); // R7

   AST_LINK_WITH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> redirect_o); // R5

   AST_LINK_MODE_IS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> (stat_lo[4:0] == link_mode_o)); // R4

   AST_ENTRY_STATE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> (!stat_lo[BIT_T] && stat_lo[BIT_I])); // R4

   AST_FIQ_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (link_we_o && link_mode_o == MODE_FIQ) |-> stat_lo[BIT_F]); // R4

   AST_IRQ_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (link_we_o && link_mode_o == MODE_IRQ) |-> !$past(stat_lo[BIT_I])); // R3

   AST_FIQ_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (link_we_o && link_mode_o == MODE_FIQ) |-> !$past(stat_lo[BIT_F])); // R3

endmodule

bind exc_entry_ctrl exc_entry_chk i_exc_entry_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .redirect_o  (redirect_o),
   .link_we_o   (link_we_o),
   .link_mode_o (link_mode_o),
   .stat_lo     (status_o[7:0])
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_dabt = 0, req_fiq = 0, req_irq = 0;
   logic        req_pabt = 0, req_swi = 0, req_und = 0;
   logic        hi_vec_sel = 0;
   logic [31:0] cur_pc = '0;
   logic        ret_req = 0;
   logic [31:0] ret_link = '0;
   logic        stat_wr_en = 0;
   logic [31:0] stat_wr_data = '0;
   logic [31:0] status_o, redirect_pc_o, link_data_o;
   logic        redirect_o, link_we_o;
   logic [4:0]  link_mode_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   exc_entry_ctrl i_exc_entry_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
      .req_pabt(req_pabt), .req_swi(req_swi), .req_und(req_und),
      .hi_vec_sel(hi_vec_sel), .cur_pc(cur_pc),
      .ret_req(ret_req), .ret_link(ret_link),
      .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
      .status_o(status_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
      .link_we_o(link_we_o), .link_mode_o(link_mode_o), .link_data_o(link_data_o)
   );

   typedef struct {
      string       tag;
      logic [31:0] pc;
      logic [31:0] st;
      logic        lwe;
      logic [4:0]  lmode;
      logic [31:0] ldata;
   } exp_t;

   exp_t exp_q[$];

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_redirect(input string tag, input logic [31:0] pc,
                                  input logic [31:0] st, input logic lwe,
                                  input logic [4:0] lmode, input logic [31:0] ldata);
      exp_t e;
      e.tag = tag; e.pc = pc; e.st = st; e.lwe = lwe; e.lmode = lmode; e.ldata = ldata;
      exp_q.push_back(e);
   endtask

   // monitor: every redirect must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && redirect_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected redirect", {32'h0, redirect_pc_o}, 64'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(redirect_pc_o == e.pc, {e.tag, " redirect pc"}, {32'h0, redirect_pc_o}, {32'h0, e.pc});
            check(status_o == e.st, {e.tag, " status"}, {32'h0, status_o}, {32'h0, e.st});
            check(link_we_o == e.lwe && (!e.lwe || (link_mode_o == e.lmode && link_data_o == e.ldata)),
                  {e.tag, " link"}, {link_we_o, 26'h0, link_mode_o, link_data_o},
                  {e.lwe, 26'h0, e.lmode, e.ldata});
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_status(input logic [31:0] v);
      stat_wr_en = 1; stat_wr_data = v;
      cyc(1);
      stat_wr_en = 0;
      check(status_o == v, "R10 status write", {32'h0, status_o}, {32'h0, v});
   endtask

   task automatic do_return(input logic [31:0] link);
      ret_req = 1; ret_link = link;
      cyc(1);
      ret_req = 0;
      cyc(1);
   endtask

   initial begin
      #500us;
      checks++; errors++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 reset state and boot redirect
      cyc(2);
      check(status_o == 32'hD3, "R1 reset status", {32'h0, status_o}, 64'hD3);
      check(redirect_o == 1'b0, "R1 no redirect in reset", {63'h0, redirect_o}, 64'h0);
      expect_redirect("R1 boot vector", 32'h0, 32'hD3, 0, 5'h0, 32'h0);
      rst_n = 1;
      cyc(3);

      wr_status(32'h10);

      // R5 R6 software interrupt from user, R8 return with no correction
      expect_redirect("R6 swi entry", 32'h08, 32'h93, 1, 5'b10011, 32'hFC);
      req_swi = 1; cur_pc = 32'h100;
      cyc(1); req_swi = 0; cyc(1);
      expect_redirect("R8 swi return", 32'hFC, 32'h10, 0, 5'h0, 32'h0);
      do_return(32'hFC);

      // R2 normal interrupt beats prefetch abort; loser taken afterwards
      expect_redirect("R2 irq wins", 32'h18, 32'h92, 1, 5'b10010, 32'h1FC);
      req_irq = 1; req_pabt = 1; cur_pc = 32'h200;
      cyc(1);
      req_irq = 0; cur_pc = 32'h300;
      expect_redirect("R2 pabt pending taken", 32'h0C, 32'h97, 1, 5'b10111, 32'h2FC);
      cyc(2);
      req_pabt = 0;
      cyc(1);
      expect_redirect("R8 pabt return minus 4", 32'h2F8, 32'h92, 0, 5'h0, 32'h0);
      do_return(32'h2FC);
      expect_redirect("R8 irq return minus 4", 32'h1F8, 32'h10, 0, 5'h0, 32'h0);
      do_return(32'h1FC);

      // R3 masked normal interrupt ignored
      wr_status(32'h90);
      req_irq = 1;
      cyc(3);
      req_irq = 0;
      check(status_o == 32'h90, "R3 masked irq ignored", {32'h0, status_o}, 64'h90);

      // R6 high vector base, fast interrupt entry
      hi_vec_sel = 1;
      expect_redirect("R6 fiq high vector", 32'hFFFF001C, 32'hD1, 1, 5'b10001, 32'h4FC);
      req_fiq = 1; cur_pc = 32'h500;
      cyc(1); req_fiq = 0; cyc(1);
      expect_redirect("R8 fiq return high", 32'h4F8, 32'h90, 0, 5'h0, 32'h0);
      do_return(32'h4FC);
      hi_vec_sel = 0;

      // R2 data abort beats fast interrupt; fiq then nests inside abort
      wr_status(32'h10);
      expect_redirect("R2 dabt wins", 32'h10, 32'h97, 1, 5'b10111, 32'h5FC);
      req_dabt = 1; req_fiq = 1; cur_pc = 32'h600;
      cyc(1);
      req_dabt = 0; cur_pc = 32'h700;
      expect_redirect("R4 fiq nested in abort", 32'h1C, 32'hD1, 1, 5'b10001, 32'h6FC);
      cyc(2);
      req_fiq = 0;
      cyc(1);
      expect_redirect("R8 fiq return restores abort", 32'h6F8, 32'h97, 0, 5'h0, 32'h0);
      do_return(32'h6FC);
      expect_redirect("R8 dabt return minus 8", 32'h5F4, 32'h10, 0, 5'h0, 32'h0);
      do_return(32'h5FC);

      // R5 software interrupt in supervisor overwrites saved state
      wr_status(32'h13);
      expect_redirect("R5 swi from svc", 32'h08, 32'h93, 1, 5'b10011, 32'h7FC);
      req_swi = 1; cur_pc = 32'h800;
      cyc(1); req_swi = 0; cyc(1);
      expect_redirect("R5 swi again in svc", 32'h08, 32'h93, 1, 5'b10011, 32'h8FC);
      req_swi = 1; cur_pc = 32'h900;
      cyc(1); req_swi = 0; cyc(1);
      expect_redirect("R5 saved slot overwritten", 32'h8FC, 32'h93, 0, 5'h0, 32'h0);
      do_return(32'h8FC);

      // R2 software interrupt beats undefined in the same cycle
      wr_status(32'h10);
      expect_redirect("R2 swi over und", 32'h08, 32'h93, 1, 5'b10011, 32'h9FC);
      req_swi = 1; req_und = 1; cur_pc = 32'hA00;
      cyc(1); req_swi = 0; req_und = 0; cyc(1);
      expect_redirect("R8 return after tie", 32'h9FC, 32'h10, 0, 5'h0, 32'h0);
      do_return(32'h9FC);

      // R4 undefined entry
      expect_redirect("R4 und entry", 32'h04, 32'h9B, 1, 5'b11011, 32'hAFC);
      req_und = 1; cur_pc = 32'hB00;
      cyc(1); req_und = 0; cyc(1);

      // R9 return ignored with state bit set
      wr_status(32'hBB);
      do_return(32'h123);
      check(status_o == 32'hBB, "R9 return ignored when state bit set", {32'h0, status_o}, 64'hBB);
      wr_status(32'h9B);
      expect_redirect("R8 und return", 32'hAFC, 32'h10, 0, 5'h0, 32'h0);
      do_return(32'hAFC);

      // R9 return ignored in user and system modes
      do_return(32'h456);
      check(status_o == 32'h10, "R9 return ignored in user", {32'h0, status_o}, 64'h10);
      wr_status(32'h1F);
      do_return(32'h456);
      check(status_o == 32'h1F, "R9 return ignored in system", {32'h0, status_o}, 64'h1F);

      // R10 entry wins over a status write in the same cycle
      expect_redirect("R10 entry beats write", 32'h04, 32'h9B, 1, 5'b11011, 32'hBFC);
      req_und = 1; cur_pc = 32'hC00; stat_wr_en = 1; stat_wr_data = 32'h10;
      cyc(1); req_und = 0; stat_wr_en = 0;
      check(status_o == 32'h9B, "R10 write dropped on entry", {32'h0, status_o}, 64'h9B);
      cyc(3);

      check(exp_q.size() == 0, "R7 all expected redirects seen",
            64'(exp_q.size()), 64'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule